// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block is the receive-side store for one USB OUT endpoint. A packet-receive engine pushes the bytes of a data packet one per cycle. At the end it either confirms the packet as good or abandons it. The block keeps up to two complete packets and presents the oldest one to a processor through a small byte-wide register bus. That bus has three registers: a control/status register, a byte-count register and a FIFO data port that pops one byte per read.

Software waits for the ready flag or the interrupt and reads the count. It then reads exactly that many bytes and frees the packet, either by writing 0 to the ready bit or by letting the auto-clear option free it on the last byte. When double buffering is enabled, a second packet can land while the first is being read. After the first is freed, the ready flag stays at 1 and the count moves to the second packet. In isochronous mode a packet that finds no free buffer is dropped and flagged as an overrun, and the interrupt still fires for it. In any other mode such a packet is refused and the engine sees a busy level it can answer with NAK.

Top module: `usb_out_epbuf`

## Requirements
- R1: After reset, the status register (address 0) reads 0x00, the count register (address 1) reads 0, `irq` is low and `rx_busy` is low.
- R2: A packet ended by `rx_good` into a free buffer sets status bit 0 (ready) and makes the count register read its byte count. It also raises `irq` for exactly one cycle, starting in the cycle after the strobe.
- R3: Reads of address 2 return the head packet's bytes in arrival order, one byte per read.
- R4: With status bit 2 (auto-clear) set, reading the last byte of the head packet frees it, and the ready bit falls with no software write.
- R5: Writing the status register with bit 0 = 0 frees the head packet. Writing bit 0 = 1 never sets ready. With auto-clear off, ready stays 1 after all bytes have been read.
- R6: With status bit 3 (double buffer) set, two packets are held. Freeing the first leaves ready at 1, switches the count to the second packet and starts FIFO reads at its first byte.
- R7: With status bit 4 (isochronous) set, a packet arriving with no free buffer is discarded, sets status bit 1 (overrun) and still pulses `irq`. Writing 1 to bit 1 clears overrun.
- R8: Outside isochronous mode, a packet arriving with no free buffer leaves the stored packet's count and data unchanged, raises no `irq` and sets no overrun. `rx_busy` is high while no buffer is free.
- R9: A packet ended by `rx_abort` raises no `irq` and does not set ready. The next packet is stored from its first byte.
- R10: A FIFO read while no packet is ready, or past the head packet's count, returns 0 and moves no read pointer.
- R11: With bit 3 clear, only one packet is held, and `rx_busy` is high while it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Engine byte strobe |
| rx_data | input | 8 | Engine byte |
| rx_good | input | 1 | End of packet, packet good |
| rx_abort | input | 1 | End of packet, discard |
| rx_busy | output | 1 | No free buffer for a new packet |
| bus_addr | input | 2 | Register select: 0 status, 1 count, 2 FIFO |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops FIFO at address 2) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on address |
| irq | output | 1 | One-cycle interrupt per received packet |

## Verification
If the head pointer or the held-packet count goes wrong, it shows at the next bus read. The count register gives the wrong packet's length, or the first FIFO byte comes from the other buffer. A ready flag that fails to hold through a double-buffer release is visible in the status read one cycle after the releasing write. A wrong take/drop decision shows as an `irq` pulse that is missing or extra in the cycle after the end strobe, or as data that has changed in the already-stored packet.

// File: rtl/usb_out_epbuf.sv
module usb_out_epbuf #(
  parameter int MAX_PKT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_good,
  input  logic       rx_abort,
  output logic       rx_busy,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int AW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1;
  localparam int CW = $clog2(MAX_PKT + 1);
  localparam logic [CW-1:0] CMAX = CW'(MAX_PKT);

  logic [7:0]    mem [2][MAX_PKT];
  logic [CW-1:0] cnt [2];
  logic [1:0]    nheld;
  logic          head;
  logic [CW-1:0] rptr, wptr;
  logic          in_pkt, take;
  logic          aclr, dbl, iso, ovr;

  logic          rdy, wbuf, space, take_now, commit, ovr_set;
  logic          csr_wr, pop, rel, wr_byte;
  logic [CW-1:0] cnt_head;
  logic [7:0]    fifo_byte;

  assign rdy      = nheld != 2'd0;
  assign wbuf     = head ^ (nheld == 2'd1);
  assign space    = nheld < (dbl ? 2'd2 : 2'd1);
  assign rx_busy  = !space;
  assign take_now = in_pkt ? take : space;
  assign commit   = rx_good && take_now && nheld != 2'd2;
  assign ovr_set  = rx_good && !commit && iso;
  assign wr_byte  = rx_valid && take_now && wptr < CMAX;

  assign cnt_head  = rdy ? cnt[head] : '0;
  assign fifo_byte = (rptr < cnt_head) ? mem[head][rptr[AW-1:0]] : 8'h00;
  assign csr_wr    = bus_wr && bus_addr == 2'd0;
  assign pop       = bus_rd && bus_addr == 2'd2 && rptr < cnt_head;
  assign rel       = rdy && ((csr_wr && !bus_wdata[0]) ||
                             (pop && aclr && rptr + 1'b1 == cnt_head));

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {3'b000, iso, dbl, aclr, ovr, rdy};
      2'd1:    bus_rdata = 8'(cnt_head);
      2'd2:    bus_rdata = fifo_byte;
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_byte) mem[wbuf][wptr[AW-1:0]] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt[0] <= '0;
      cnt[1] <= '0;
      nheld  <= 2'd0;
      head   <= 1'b0;
      rptr   <= '0;
      wptr   <= '0;
      in_pkt <= 1'b0;
      take   <= 1'b0;
      aclr   <= 1'b0;
      dbl    <= 1'b0;
      iso    <= 1'b0;
      ovr    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= commit || ovr_set;
      if (rx_good || rx_abort) begin
        in_pkt <= 1'b0;
        wptr   <= '0;
      end else if (rx_valid) begin
        in_pkt <= 1'b1;
        take   <= take_now;
        if (wr_byte) wptr <= wptr + 1'b1;
      end
      if (commit) cnt[wbuf] <= wptr;
      nheld <= nheld + {1'b0, commit} - {1'b0, rel};
      if (rel) begin
        head <= ~head;
        rptr <= '0;
      end else if (pop) begin
        rptr <= rptr + 1'b1;
      end
      if (csr_wr) begin
        aclr <= bus_wdata[2];
        dbl  <= bus_wdata[3];
        iso  <= bus_wdata[4];
      end
      if (ovr_set) ovr <= 1'b1;
      else if (csr_wr && bus_wdata[1]) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_out_epbuf_chk.sv
module usb_out_epbuf_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_good,
  input logic          iso,
  input logic          irq,
  input logic          rdy,
  input logic          ovr,
  input logic [CW-1:0] rptr,
  input logic [CW-1:0] cnt_head,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [7:0]    bus_rdata
);
  AST_IRQ_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_good)); // R2
  AST_RDY_NEEDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(rx_good)); // R2
  AST_RPTR_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    rptr <= cnt_head); // R10
  AST_ISO_IRQ_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_good) && $past(iso)) |-> irq); // R7
  AST_OVR_ONLY_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($past(rx_good) && $past(iso))); // R8
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && bus_rd && bus_addr == 2'd2) |-> bus_rdata == 8'h00); // R10
endmodule

bind usb_out_epbuf usb_out_epbuf_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_good(rx_good), .iso(iso), .irq(irq),
  .rdy(rdy), .ovr(ovr), .rptr(rptr), .cnt_head(cnt_head),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_usb_out_epbuf.sv
module tb_usb_out_epbuf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_good = 1'b0, rx_abort = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_busy, irq;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  int nchk = 0, nbad = 0;

  always #2 clk = ~clk;

  usb_out_epbuf #(.MAX_PKT(64)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_good(rx_good), .rx_abort(rx_abort), .rx_busy(rx_busy),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // length, seed
  localparam logic [15:0] VEC [5] = '{
    {8'd1, 8'h11}, {8'd4, 8'hA0}, {8'd7, 8'h3C}, {8'd16, 8'hF0}, {8'd64, 8'h05}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input int len, input logic [7:0] seed, input bit good);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_data  = seed + 8'(i * 3);
      tick();
    end
    rx_valid = 1'b0;
    if (good) rx_good = 1'b1; else rx_abort = 1'b1;
    tick();
    rx_good = 1'b0;
    rx_abort = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_rd = 1'b1;
    #1 d = bus_rdata;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic read_pkt(input string req, input int len, input logic [7:0] seed);
    logic [7:0] d;
    for (int i = 0; i < len; i++) begin
      rd(2'd2, d);
      chk(req, d, 8'(seed + 8'(i * 3)));
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    rd(2'd0, d); chk("R1 status", d, 8'h00);
    rd(2'd1, d); chk("R1 count", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 busy", rx_busy, 0);

    // R2 R3 R4 table walk, auto-clear on, single buffer
    wr(2'd0, 8'h05);
    foreach (VEC[k]) begin
      send(int'(VEC[k][15:8]), VEC[k][7:0], 1'b1);
      chk("R2 irq pulse", irq, 1);
      rd(2'd0, d); chk("R2 ready", d[0], 1);
      chk("R2 irq one cycle", irq, 0);
      rd(2'd1, d); chk("R2 count", d, int'(VEC[k][15:8]));
      read_pkt("R3 data", int'(VEC[k][15:8]), VEC[k][7:0]);
      rd(2'd0, d); chk("R4 auto clear", d[0], 0);
    end

    // R10 R5 manual clear
    wr(2'd0, 8'h01);
    rd(2'd2, d); chk("R10 empty read", d, 0);
    send(3, 8'h10, 1'b1);
    read_pkt("R10 pointer kept", 3, 8'h10);
    rd(2'd2, d); chk("R10 past count", d, 0);
    rd(2'd0, d); chk("R5 ready held", d[0], 1);
    wr(2'd0, 8'h01);
    rd(2'd0, d); chk("R5 write one", d[0], 1);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R5 write zero", d[0], 0);

    // R11 R8 single capacity, non-iso reject
    send(2, 8'h20, 1'b1);
    chk("R11 busy", rx_busy, 1);
    send(5, 8'h40, 1'b1);
    chk("R8 no irq", irq, 0);
    rd(2'd1, d); chk("R8 count kept", d, 2);
    rd(2'd0, d); chk("R8 no overrun", d[1], 0);
    read_pkt("R8 data kept", 2, 8'h20);
    wr(2'd0, 8'h00);
    chk("R11 busy free", rx_busy, 0);

    // R6 double buffer
    wr(2'd0, 8'h09);
    send(3, 8'h50, 1'b1);
    chk("R6 room for second", rx_busy, 0);
    send(5, 8'h60, 1'b1);
    chk("R6 busy", rx_busy, 1);
    rd(2'd1, d); chk("R6 first count", d, 3);
    read_pkt("R6 first data", 3, 8'h50);
    wr(2'd0, 8'h08);
    rd(2'd0, d); chk("R6 ready stays", d[0], 1);
    rd(2'd1, d); chk("R6 count switch", d, 5);
    read_pkt("R6 second data", 5, 8'h60);
    wr(2'd0, 8'h08);
    rd(2'd0, d); chk("R6 empty", d[0], 0);

    // R7 isochronous overrun
    wr(2'd0, 8'h19);
    send(2, 8'h70, 1'b1);
    send(4, 8'h78, 1'b1);
    send(6, 8'h90, 1'b1);
    chk("R7 irq on overrun", irq, 1);
    rd(2'd0, d); chk("R7 status", d, 8'h1B);
    rd(2'd1, d); chk("R7 count kept", d, 2);
    read_pkt("R7 data kept", 2, 8'h70);
    wr(2'd0, 8'h1B);
    rd(2'd0, d); chk("R7 w1c", d[1], 0);
    wr(2'd0, 8'h18);
    rd(2'd1, d); chk("R7 second count", d, 4);
    wr(2'd0, 8'h18);

    // R9 abort
    wr(2'd0, 8'h01);
    send(4, 8'hA5, 1'b0);
    chk("R9 no irq", irq, 0);
    rd(2'd0, d); chk("R9 not ready", d[0], 0);
    send(2, 8'h80, 1'b1);
    rd(2'd1, d); chk("R9 next count", d, 2);
    read_pkt("R9 next data", 2, 8'h80);

    summary();
  end
endmodule